// File: doc/BRIEF.md
# CRC-4 Multiframe Aligner with Interworking Decision

This block sits behind a basic frame aligner on a 2.048 Mbit/s receive path. Once basic frame alignment is held, it takes bit 1 of time slot 0 in every frame. It keeps only the bits from the frames that do not carry the frame alignment signal, and it hunts in those bits for the six-bit CRC-4 multiframe alignment word. A candidate word must be followed by a second, error-free word at exactly the next multiframe position before CRC-4 multiframe sync is declared. After that, the block keeps a frame-in-multiframe counter for the downstream CRC-4 checker and E-bit logic.

The block also settles whether the far end runs CRC-4 at all. When automatic interworking is enabled, a frame-count timer starts when basic alignment is gained. If CRC-4 sync is not reached before the timer runs out, the far end is classed as non-CRC-4. Receive CRC-4 processing is then switched off and the transmitted E-bits are forced to zero. CRC-4 transmission itself goes on. A hold input can also force the E-bits to zero while the outcome is still open. The timeout is a port. A value of 3200 frames matches a 400 ms window.

Top module: `crc4_mfa_iw`

## Requirements
- R1: During reset, and while basic alignment is absent (`basic_sync_n`=1), `crc_sync_n`=1, `far_noncrc`=0, `rx_crc_en`=0 and `mf_frame`=0.
- R2: The hunt looks only at `rx_bit` on strobes with `nfas_frame`=1. The alignment word is read oldest first from frames 1,3,5,7,9,11 as 0,0,1,0,1,1. Bits taken on strobes with `nfas_frame`=0 have no effect on when sync is reached.
- R3: `crc_sync_n` falls on the frame-11 strobe that completes a second correct alignment word. That strobe is exactly 16 frames after the frame-11 strobe that completed the first word, and `crc_sync_n` is 1 after the strobe just before it.
- R4: During confirmation, a wrong alignment bit sends the block back to the hunt with no bits retained. Two fresh, complete words are then needed.
- R5: While hunting, `mf_frame`=0. From the first detected word onwards, `mf_frame` holds the number (0..15) of the latest frame, which is 11 at detection. It advances by one, modulo 16, on every `bit1_stb`.
- R6: Loss of basic alignment clears the sync state, the frame counter, the timer and the non-CRC-4 verdict within one clock.
- R7: With `auto_iw_n`=0 and no CRC-4 sync, `far_noncrc` rises on the N-th strobe after basic alignment, where N=`timeout_frames`. A value of 0 behaves as 1.
- R8: While `far_noncrc`=1, `rx_crc_en`=0, `tx_ebit_zero`=1, and the hunt is suspended, so `crc_sync_n` stays 1 even for a valid stream.
- R9: If CRC-4 sync is reached on or before the N-th strobe, `far_noncrc` stays 0. With sync, `rx_crc_en`=1 and `tx_ebit_zero`=0.
- R10: With `auto_iw_n`=1, `far_noncrc` never rises.
- R11: While neither CRC-4 sync nor the non-CRC-4 verdict is present, `tx_ebit_zero` equals `ebit_hold`.
- R12: During confirmation, the bits in frames 13 and 15 are not compared, so either value leads to sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit1_stb | input | 1 | One-cycle strobe, once per frame, when bit 1 of time slot 0 is on `rx_bit` |
| nfas_frame | input | 1 | 1 when the current frame is a non-frame-alignment (odd) frame |
| rx_bit | input | 1 | Received bit, valid with `bit1_stb` |
| basic_sync_n | input | 1 | Basic frame alignment, active low |
| auto_iw_n | input | 1 | 0 enables the automatic interworking timer |
| ebit_hold | input | 1 | 1 forces the E-bits to zero until the interworking outcome is known |
| timeout_frames | input | TIMER_W | Interworking timeout, in frames |
| crc_sync_n | output | 1 | CRC-4 multiframe sync, active low |
| mf_frame | output | 4 | Frame number within the CRC-4 multiframe; bit 3 selects the sub-multiframe |
| far_noncrc | output | 1 | Far end classed as non-CRC-4 |
| rx_crc_en | output | 1 | Receive CRC-4 processing enabled |
| tx_ebit_zero | output | 1 | Force transmitted E-bits to zero |

## Verification
The assertions assume that `bit1_stb` comes once per frame as a single-cycle pulse. They also assume that `nfas_frame` alternates in step with the true frame numbering, so that the parity the hunt uses agrees with the counter used during confirmation. The bench keeps to this by building every stream from a frame number that advances by one per strobe, and by deriving `nfas_frame` from that number's low bit. It sweeps all 16 starting frame phases and both E-bit values. Basic alignment changes only between strobes, and at least one idle cycle separates strobes.

// File: rtl/crc4_mfa_pkg.sv
package crc4_mfa_pkg;
  localparam int WORD_LEN        = 6;
  localparam int MF_W            = 4;
  localparam int LAST_WORD_FRAME = 11;
  localparam int FILL_W          = $clog2(WORD_LEN + 1);
  localparam logic [WORD_LEN-1:0] MFA_WORD = 6'b001011;

  typedef enum logic [1:0] {
    MFA_HUNT    = 2'd0,
    MFA_CONFIRM = 2'd1,
    MFA_LOCKED  = 2'd2
  } mfa_state_e;

  // frame carries an alignment bit: odd and not past frame 11
  function automatic logic is_word_frame(input logic [MF_W-1:0] fr);
    return fr[0] && (fr <= MF_W'(LAST_WORD_FRAME));
  endfunction

  // expected alignment bit for an odd frame number, oldest bit is the MSB
  function automatic logic word_bit(input logic [MF_W-1:0] fr);
    logic [WORD_LEN-1:0] tmp;
    tmp = MFA_WORD << fr[MF_W-1:1];
    return tmp[WORD_LEN-1];
  endfunction
endpackage

// File: rtl/crc4_mfa_search.sv
module crc4_mfa_search
  import crc4_mfa_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            suspend,
  input  logic            strobe,
  input  logic            nfas,
  input  logic            rx_bit,
  output mfa_state_e      state_o,
  output logic [MF_W-1:0] frame_o,
  output logic            lock_hit_o
);
  mfa_state_e            state_q, state_d;
  logic [MF_W-1:0]       frame_q, frame_d, cur_fr;
  logic [WORD_LEN-1:0]   sh_q, sh_d, shifted;
  logic [FILL_W-1:0]     fill_q, fill_d;

  assign cur_fr  = frame_q + MF_W'(1);
  assign shifted = {sh_q[WORD_LEN-2:0], rx_bit};

  always_comb begin
    state_d    = state_q;
    frame_d    = frame_q;
    sh_d       = sh_q;
    fill_d     = fill_q;
    lock_hit_o = 1'b0;
    if (strobe) begin
      case (state_q)
        MFA_HUNT: begin
          if (!suspend && nfas) begin
            sh_d = shifted;
            if (fill_q != FILL_W'(WORD_LEN)) fill_d = fill_q + FILL_W'(1);
            if (fill_q >= FILL_W'(WORD_LEN - 1) && shifted == MFA_WORD) begin
              state_d = MFA_CONFIRM;
              frame_d = MF_W'(LAST_WORD_FRAME);
            end
          end
        end
        MFA_CONFIRM: begin
          if (suspend || (is_word_frame(cur_fr) && rx_bit != word_bit(cur_fr))) begin
            state_d = MFA_HUNT;
            frame_d = '0;
            sh_d    = '0;
            fill_d  = '0;
          end else begin
            frame_d = cur_fr;
            if (cur_fr == MF_W'(LAST_WORD_FRAME)) begin
              state_d    = MFA_LOCKED;
              lock_hit_o = 1'b1;
            end
          end
        end
        MFA_LOCKED: frame_d = cur_fr;
        default:    state_d = MFA_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= MFA_HUNT;
      frame_q <= '0;
      sh_q    <= '0;
      fill_q  <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      sh_q    <= sh_d;
      fill_q  <= fill_d;
    end
  end

  assign state_o = state_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/crc4_iw_timer.sv
module crc4_iw_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               strobe,
  input  logic               enable_n,
  input  logic               locked,
  input  logic [TIMER_W-1:0] timeout,
  output logic               far_o
);
  logic [TIMER_W-1:0] cnt_q;
  logic [TIMER_W:0]   cnt_nxt;
  logic               far_q;

  assign cnt_nxt = {1'b0, cnt_q} + (TIMER_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      far_q <= 1'b0;
    end else if (strobe && !enable_n && !far_q && !locked) begin
      if (cnt_nxt >= {1'b0, timeout}) far_q <= 1'b1;
      else                            cnt_q <= cnt_nxt[TIMER_W-1:0];
    end
  end

  assign far_o = far_q;
endmodule

// File: rtl/crc4_mfa_iw.sv
module crc4_mfa_iw
  import crc4_mfa_pkg::*;
#(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit1_stb,
  input  logic               nfas_frame,
  input  logic               rx_bit,
  input  logic               basic_sync_n,
  input  logic               auto_iw_n,
  input  logic               ebit_hold,
  input  logic [TIMER_W-1:0] timeout_frames,
  output logic               crc_sync_n,
  output logic [MF_W-1:0]    mf_frame,
  output logic               far_noncrc,
  output logic               rx_crc_en,
  output logic               tx_ebit_zero
);
  mfa_state_e state;
  logic       lock_hit, far, locked_now, aligned_q;

  crc4_mfa_search u_search (
    .clk        (clk),
    .rst        (rst),
    .clr        (basic_sync_n),
    .suspend    (far),
    .strobe     (bit1_stb),
    .nfas       (nfas_frame),
    .rx_bit     (rx_bit),
    .state_o    (state),
    .frame_o    (mf_frame),
    .lock_hit_o (lock_hit)
  );

  assign locked_now = lock_hit || (state == MFA_LOCKED);

  crc4_iw_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (basic_sync_n),
    .strobe   (bit1_stb),
    .enable_n (auto_iw_n),
    .locked   (locked_now),
    .timeout  (timeout_frames),
    .far_o    (far)
  );

  always_ff @(posedge clk) begin
    if (rst) aligned_q <= 1'b0;
    else     aligned_q <= !basic_sync_n;
  end

  assign crc_sync_n   = (state != MFA_LOCKED);
  assign far_noncrc   = far;
  assign rx_crc_en    = aligned_q && !far;
  assign tx_ebit_zero = far || (ebit_hold && state != MFA_LOCKED);
endmodule

// File: rtl/crc4_mfa_iw_chk.sv
module crc4_mfa_iw_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit1_stb,
  input logic       basic_sync_n,
  input logic       auto_iw_n,
  input logic       crc_sync_n,
  input logic [3:0] mf_frame,
  input logic       far_noncrc,
  input logic       rx_crc_en,
  input logic       tx_ebit_zero
);
  assert_basic_loss_R6: assert property (@(posedge clk) disable iff (rst)
    basic_sync_n |=> (crc_sync_n && !far_noncrc && mf_frame == 4'd0));

  assert_lock_at_frame11_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(crc_sync_n) |-> mf_frame == 4'd11);

  assert_frame_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!crc_sync_n && $past(!crc_sync_n) && $past(bit1_stb)) |-> mf_frame == $past(mf_frame) + 4'd1);

  assert_quiet_without_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (!bit1_stb && !basic_sync_n) |=> ($stable(mf_frame) && $stable(crc_sync_n) && $stable(far_noncrc)));

  assert_noncrc_suspends_R8: assert property (@(posedge clk) disable iff (rst)
    far_noncrc |-> (crc_sync_n && !rx_crc_en && tx_ebit_zero));

  assert_sync_normal_ebits_R9: assert property (@(posedge clk) disable iff (rst)
    !crc_sync_n |-> (!far_noncrc && !tx_ebit_zero));

  assert_auto_off_R10: assert property (@(posedge clk) disable iff (rst)
    (auto_iw_n && !far_noncrc) |=> !far_noncrc);
endmodule

bind crc4_mfa_iw crc4_mfa_iw_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit1_stb     (bit1_stb),
  .basic_sync_n (basic_sync_n),
  .auto_iw_n    (auto_iw_n),
  .crc_sync_n   (crc_sync_n),
  .mf_frame     (mf_frame),
  .far_noncrc   (far_noncrc),
  .rx_crc_en    (rx_crc_en),
  .tx_ebit_zero (tx_ebit_zero)
);

// File: tb/crc4_mfa_iw_bench.sv
module crc4_mfa_iw_bench;
  localparam int TW = 12;
  localparam logic [5:0] ALIGN = 6'b001011;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit1_stb = 1'b0, nfas_frame = 1'b0, rx_bit = 1'b0;
  logic          basic_sync_n = 1'b1, auto_iw_n = 1'b0, ebit_hold = 1'b0;
  logic [TW-1:0] timeout_frames = TW'(4000);
  logic          crc_sync_n, far_noncrc, rx_crc_en, tx_ebit_zero;
  logic [3:0]    mf_frame;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  crc4_mfa_iw #(.TIMER_W(TW)) u_crc4_mfa_iw (
    .clk(clk), .rst(rst), .bit1_stb(bit1_stb), .nfas_frame(nfas_frame),
    .rx_bit(rx_bit), .basic_sync_n(basic_sync_n), .auto_iw_n(auto_iw_n),
    .ebit_hold(ebit_hold), .timeout_frames(timeout_frames),
    .crc_sync_n(crc_sync_n), .mf_frame(mf_frame), .far_noncrc(far_noncrc),
    .rx_crc_en(rx_crc_en), .tx_ebit_zero(tx_ebit_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bit 1 of time slot 0 for frame fr of a correct CRC-4 multiframe
  function automatic logic line_bit(input int fr, input logic ebit);
    if (fr % 2 == 1) begin
      if (fr <= 11) return ALIGN[5 - (fr - 1) / 2];
      return ebit;
    end
    return logic'(((fr >> 1) ^ (fr >> 2)) & 1);
  endfunction

  task automatic send(input int fr, input logic b);
    bit1_stb   = 1'b1;
    nfas_frame = logic'(fr % 2);
    rx_bit     = b;
    @(negedge clk);
    bit1_stb   = 1'b0;
    @(negedge clk);
  endtask

  task automatic realign();
    basic_sync_n = 1'b1;
    @(negedge clk);
    basic_sync_n = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset and unaligned state
    check("R1 crc_sync_n", int'(crc_sync_n), 1);
    check("R1 far_noncrc", int'(far_noncrc), 0);
    check("R1 rx_crc_en", int'(rx_crc_en), 0);
    check("R1 mf_frame", int'(mf_frame), 0);

    // sweep every start phase; even frames carry noise (R2), E-bits vary (R12)
    for (int s = 0; s < 16; s++) begin
      int ksync;
      logic ebit;
      ebit           = logic'((s >> 1) & 1);
      ebit_hold      = logic'(s & 1);
      auto_iw_n      = 1'b0;
      timeout_frames = TW'(4000);
      ksync = ((s <= 1) ? (11 - s) : (27 - s)) + 16;
      realign();
      for (int k = 0; k <= ksync + 3; k++) begin
        int fr;
        fr = (s + k) % 16;
        send(fr, line_bit(fr, ebit));
        if (k == ksync - 1) begin
          check("R3 no sync before second word", int'(crc_sync_n), 1);
          check("R11 ebit hold while open", int'(tx_ebit_zero), int'(ebit_hold));
        end
        if (k == ksync) begin
          check("R3 R2 R12 sync on second word", int'(crc_sync_n), 0);
          check("R5 frame 11 at sync", int'(mf_frame), 11);
        end
      end
      check("R5 frame counts on", int'(mf_frame), 14);
      check("R9 rx_crc_en with sync", int'(rx_crc_en), 1);
      check("R9 tx_ebit_zero with sync", int'(tx_ebit_zero), 0);
      check("R9 far_noncrc with sync", int'(far_noncrc), 0);
    end

    // R6: basic loss clears the lock
    basic_sync_n = 1'b1;
    @(negedge clk);
    check("R6 sync cleared", int'(crc_sync_n), 1);
    check("R6 frame cleared", int'(mf_frame), 0);
    check("R1 rx_crc_en unaligned", int'(rx_crc_en), 0);

    // R4: bad frame-5 bit in the confirming multiframe
    ebit_hold = 1'b0;
    realign();
    for (int k = 0; k < 64; k++) begin
      int fr;
      logic b;
      fr = k % 16;
      b  = line_bit(fr, 1'b1);
      if (k == 21) b = ~b;
      send(fr, b);
      if (k == 27) check("R4 no sync after bad word", int'(crc_sync_n), 1);
      if (k == 43) check("R4 no sync after one fresh word", int'(crc_sync_n), 1);
      if (k == 59) check("R4 sync after two fresh words", int'(crc_sync_n), 0);
    end

    // R7 / R8: timer expiry with a stream lacking the word
    timeout_frames = TW'(20);
    realign();
    for (int k = 1; k <= 20; k++) begin
      send(k % 16, 1'b1);
      if (k == 19) check("R7 not yet expired", int'(far_noncrc), 0);
    end
    check("R7 expired at N", int'(far_noncrc), 1);
    check("R8 rx_crc_en off", int'(rx_crc_en), 0);
    check("R8 ebits forced", int'(tx_ebit_zero), 1);
    for (int k = 0; k < 40; k++) send(k % 16, line_bit(k % 16, 1'b1));
    check("R8 hunt suspended", int'(crc_sync_n), 1);
    basic_sync_n = 1'b1;
    @(negedge clk);
    check("R6 verdict cleared", int'(far_noncrc), 0);

    // R7: zero timeout acts as one
    timeout_frames = TW'(0);
    realign();
    send(0, 1'b0);
    check("R7 zero timeout", int'(far_noncrc), 1);

    // R9: sync on the very strobe the timer would expire
    timeout_frames = TW'(28);
    realign();
    for (int k = 0; k < 28; k++) send(k % 16, line_bit(k % 16, 1'b1));
    check("R9 sync wins race", int'(crc_sync_n), 0);
    check("R9 no verdict", int'(far_noncrc), 0);

    // R7 / R8: timer one frame earlier aborts confirmation
    timeout_frames = TW'(27);
    realign();
    for (int k = 0; k < 28; k++) begin
      send(k % 16, line_bit(k % 16, 1'b1));
      if (k == 26) check("R7 expired before sync", int'(far_noncrc), 1);
    end
    check("R8 confirmation aborted", int'(crc_sync_n), 1);

    // R10: interworking disabled
    auto_iw_n      = 1'b1;
    ebit_hold      = 1'b1;
    timeout_frames = TW'(5);
    realign();
    for (int k = 0; k < 30; k++) send(k % 16, 1'b1);
    check("R10 no verdict", int'(far_noncrc), 0);
    check("R11 hold applies", int'(tx_ebit_zero), 1);
    check("R10 rx_crc_en stays", int'(rx_crc_en), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule